// File: doc/BRIEF.md
# DMA Write Request Segmenter

This block turns one device-to-host block transfer into a train of memory-write requests for a transaction layer. A start command supplies a 64-bit host byte address, a byte count and a 3-bit payload-size code. The block then presents one request header at a time. Each header carries the start address, the length in dwords, and the first and last byte enables. After each header it streams that request's payload as 32-bit words. The payload comes from a local one-byte-per-beat stream and is placed in the byte lane that matches the host address.

Each request stops at the payload limit, and also at the next 4 KiB host boundary, whichever comes first. When the final payload word of the block has been taken, a one-cycle interrupt pulse reports completion. An illegal payload-size code stops the transfer before it starts and raises the same pulse with an error flag. Every interface uses a plain valid/ready handshake.

Top module: `dma_wr_segmenter`

## Requirements
- R1: The payload-size code n (0 to 5) sets a limit of 128·2^n bytes. No request carries more bytes than that limit or spans two limit-aligned blocks. The length of a request is the smallest of three values: the bytes remaining, the bytes left to the next 4 KiB boundary, and the limit minus the address offset inside its limit-aligned block.
- R2: No request crosses a 4 KiB host address boundary.
- R3: Successive request addresses are contiguous, starting at the command address, and the request byte counts add up to the command length. The dword length is (address[1:0] + bytes + 3) / 4.
- R4: First byte enable bit k (bit k is the byte at address offset k within a dword) is set exactly for the request bytes in the first dword.
- R5: A one-dword request has a last byte enable of 0000. A longer request has a last byte enable that covers the bytes of its final dword: 1111 when the end address is dword aligned, otherwise the low (end mod 4) lanes.
- R6: Stream byte i of a request goes to lane (address + i) mod 4 of the payload words, with bits 8k+7:8k as lane k. Lanes outside the request read zero. Each request gives exactly its dword length of words, and the last-word flag marks the final one. The whole block consumes exactly the command length in stream bytes.
- R7: The interrupt pulse is high for exactly one cycle, in the cycle after the final payload word is accepted. The error flag is low and busy has dropped in that cycle.
- R8: A start command with payload-size code 6 or 7 gives an interrupt pulse with the error flag set in the next cycle, and issues no requests.
- R9: A zero-length command gives an interrupt pulse without the error flag in the next cycle, and issues no requests.
- R10: Busy is high from the cycle after an accepted command until completion. A start command seen while busy is ignored.
- R11: After reset, busy, request valid, payload valid, stream ready and the interrupt pulse are all low.
- R12: While a request header is valid and not yet accepted, the header stays valid and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Start command strobe, sampled when idle |
| cmdAddr | input | 64 | Host byte start address |
| cmdLen | input | 16 | Transfer length in bytes |
| cmdMps | input | 3 | Payload-size code, limit 128·2^n bytes |
| busy | output | 1 | Transfer in progress |
| reqValid | output | 1 | Request header valid |
| reqReady | input | 1 | Header accepted by the transaction layer |
| reqAddr | output | 64 | Request host byte address |
| reqDwLen | output | 11 | Request length in dwords |
| reqFirstBe | output | 4 | First dword byte enables |
| reqLastBe | output | 4 | Last dword byte enables |
| inValid | input | 1 | Local payload byte valid |
| inByte | input | 8 | Local payload byte |
| inReady | output | 1 | Payload byte accepted |
| dataValid | output | 1 | Payload word valid |
| dataReady | input | 1 | Payload word accepted |
| dataWord | output | 32 | Lane-aligned payload word |
| dataLast | output | 1 | Final word of the current request |
| irqPulse | output | 1 | One-cycle completion interrupt |
| irqErr | output | 1 | Qualifies irqPulse as an error stop |

## Verification
Aligned transfers at the smallest limit separate cutting at the payload limit from cutting at 4 KiB. A start just below a 4 KiB line with the largest limit tests the boundary cut alone. A start in the middle of a limit-aligned block tests the offset term of the length rule. One- to three-byte and odd-offset transfers tell the first and last byte enable rules apart and show the lane shift. Random addresses, lengths and codes, with random stalls on all three handshakes, exercise header hold and stream pacing. Illegal codes, a zero length and a command sent during a busy transfer cover the paths that must produce no requests.

// File: rtl/wrseg_pkg.sv
package wrseg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_DATA = 2'd2
  } segState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCmd;
    logic hdrShow;
    logic hdrTake;
    logic dataPhase;
  } segCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic remZero;
    logic dataDone;
  } segStat_t;

endpackage

// File: rtl/wrseg_ctrl.sv
module wrseg_ctrl
  import wrseg_pkg::*;
#(
  parameter int LEN_W        = 16,
  parameter int MPS_CODE_MAX = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [LEN_W-1:0] cmdLen,
  input  logic [2:0]       cmdMps,
  input  logic             reqReady,
  input  segStat_t         stat,
  output segCtl_t          ctl,
  output logic             reqValid,
  output logic             busy,
  output logic             irqPulse,
  output logic             irqErr
);

  segState_e state;
  logic      codeBad;
  logic      lenZero;

  assign codeBad  = (32'(cmdMps) > MPS_CODE_MAX);
  assign lenZero  = (cmdLen == '0);
  assign reqValid = (state == ST_HDR);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    ctl           = '0;
    ctl.loadCmd   = (state == ST_IDLE) && cmdValid && !codeBad && !lenZero;
    ctl.hdrShow   = (state == ST_HDR);
    ctl.hdrTake   = (state == ST_HDR) && reqReady;
    ctl.dataPhase = (state == ST_DATA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      irqPulse <= 1'b0;
      irqErr   <= 1'b0;
    end else begin
      irqPulse <= 1'b0;
      irqErr   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cmdValid) begin
            if (codeBad) begin
              irqPulse <= 1'b1;
              irqErr   <= 1'b1;
            end else if (lenZero) begin
              irqPulse <= 1'b1;
            end else begin
              state <= ST_HDR;
            end
          end
        end
        ST_HDR: begin
          if (reqReady) state <= ST_DATA;
        end
        ST_DATA: begin
          if (stat.dataDone) begin
            if (stat.remZero) begin
              state    <= ST_IDLE;
              irqPulse <= 1'b1;
            end else begin
              state <= ST_HDR;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse); // R7

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse && !irqErr && $past(state == ST_DATA)) |-> $past(stat.dataDone)); // R7

  AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    irqErr |=> !reqValid); // R8

  AST_BUSY_HOLDS_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(stat.dataDone && stat.remZero)) |=> busy); // R10

endmodule

// File: rtl/wrseg_dpath.sv
module wrseg_dpath
  import wrseg_pkg::*;
#(
  parameter int ADDR_W        = 64,
  parameter int LEN_W         = 16,
  parameter int BOUND_LOG2    = 12,
  parameter int MPS_BASE_LOG2 = 7,
  localparam int CHUNK_W      = BOUND_LOG2 + 1,
  localparam int DWLEN_W      = BOUND_LOG2 - 1,
  localparam int CMP_W        = (LEN_W > CHUNK_W) ? LEN_W : CHUNK_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  segCtl_t            ctl,
  input  logic [ADDR_W-1:0]  cmdAddr,
  input  logic [LEN_W-1:0]   cmdLen,
  input  logic [2:0]         cmdMps,
  output logic [ADDR_W-1:0]  reqAddr,
  output logic [DWLEN_W-1:0] reqDwLen,
  output logic [3:0]         reqFirstBe,
  output logic [3:0]         reqLastBe,
  input  logic               inValid,
  input  logic [7:0]         inByte,
  output logic               inReady,
  output logic               dataValid,
  input  logic               dataReady,
  output logic [31:0]        dataWord,
  output logic               dataLast,
  output segStat_t           stat
);

  logic [ADDR_W-1:0]  curAddr;
  logic [LEN_W-1:0]   remBytes;
  logic [2:0]         mpsCode;
  logic [CHUNK_W-1:0] bytesLeft;
  logic [1:0]         lane;
  logic [31:0]        wordQ;
  logic               outFull;
  logic               outLast;

  logic [CHUNK_W-1:0] toBound;
  logic [CHUNK_W-1:0] mpsBytes;
  logic [CHUNK_W-1:0] mpsRoom;
  logic [CHUNK_W-1:0] chunk;
  logic [CHUNK_W:0]   span;
  logic [1:0]         startOff;
  logic [1:0]         endLane;
  logic               inFire;
  logic               outFire;

  // length of the next request: smallest of boundary room, payload room, remainder
  always_comb begin
    startOff = curAddr[1:0];
    toBound  = CHUNK_W'(1 << BOUND_LOG2) - CHUNK_W'(curAddr[BOUND_LOG2-1:0]);
    mpsBytes = CHUNK_W'(1) << (MPS_BASE_LOG2 + 32'(mpsCode));
    mpsRoom  = mpsBytes - (CHUNK_W'(curAddr[BOUND_LOG2-1:0]) & (mpsBytes - CHUNK_W'(1)));
    chunk    = toBound;
    if (mpsRoom < chunk) chunk = mpsRoom;
    if (CMP_W'(remBytes) < CMP_W'(chunk)) chunk = CHUNK_W'(remBytes);
    span     = (CHUNK_W+1)'(startOff) + (CHUNK_W+1)'(chunk) + (CHUNK_W+1)'(3);
  end

  assign reqAddr  = curAddr;
  assign reqDwLen = DWLEN_W'(span >> 2);
  assign endLane  = 2'(startOff + chunk[1:0]);

  always_comb begin
    for (int l = 0; l < 4; l++) begin
      reqFirstBe[l] = (l >= int'(startOff)) && (l < int'(startOff) + int'(chunk));
    end
    if (reqDwLen == DWLEN_W'(1)) reqLastBe = 4'b0000;
    else if (endLane == 2'd0)    reqLastBe = 4'b1111;
    else                         reqLastBe = (4'b0001 << endLane) - 4'b0001;
  end

  // command and request bookkeeping
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      remBytes <= '0;
      mpsCode  <= '0;
    end else if (ctl.loadCmd) begin
      curAddr  <= cmdAddr;
      remBytes <= cmdLen;
      mpsCode  <= cmdMps;
    end else if (ctl.hdrTake) begin
      curAddr  <= curAddr + ADDR_W'(chunk);
      remBytes <= remBytes - LEN_W'(chunk);
    end
  end

  // byte packer: each byte goes to the lane its host address selects
  assign inReady  = ctl.dataPhase && !outFull && (bytesLeft != '0);
  assign inFire   = inReady && inValid;
  assign outFire  = outFull && dataReady;
  assign dataValid = outFull;
  assign dataWord  = wordQ;
  assign dataLast  = outLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bytesLeft <= '0;
      lane      <= '0;
      wordQ     <= '0;
      outFull   <= 1'b0;
      outLast   <= 1'b0;
    end else begin
      if (ctl.hdrTake) begin
        bytesLeft <= chunk;
        lane      <= startOff;
      end else if (inFire) begin
        wordQ[{lane, 3'b000} +: 8] <= inByte;
        lane      <= lane + 2'd1;
        bytesLeft <= bytesLeft - CHUNK_W'(1);
        if (lane == 2'd3 || bytesLeft == CHUNK_W'(1)) begin
          outFull <= 1'b1;
          outLast <= (bytesLeft == CHUNK_W'(1));
        end
      end
      if (outFire) begin
        outFull <= 1'b0;
        outLast <= 1'b0;
        wordQ   <= '0;
      end
    end
  end

  assign stat.remZero  = (remBytes == '0);
  assign stat.dataDone = outFire && outLast;

  AST_MPS_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.hdrShow |-> (chunk <= mpsBytes) && (chunk != '0)); // R1

  AST_NO_BOUND_CROSS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.hdrShow |-> ((CHUNK_W+1)'(reqAddr[BOUND_LOG2-1:0]) + (CHUNK_W+1)'(chunk)
                     <= (CHUNK_W+1)'(1 << BOUND_LOG2))); // R2

  AST_FIRSTBE_SET: assert property (@(posedge clk) disable iff (!rstN)
    ctl.hdrShow |-> (reqFirstBe != 4'b0000)); // R4

  AST_SINGLE_DW_LASTBE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.hdrShow && reqDwLen == DWLEN_W'(1)) |-> (reqLastBe == 4'b0000)); // R5

  AST_MULTI_DW_LASTBE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.hdrShow && reqDwLen > DWLEN_W'(1)) |-> (reqLastBe != 4'b0000)); // R5

  AST_DATA_NOT_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    stat.dataDone |-> (bytesLeft == '0)); // R6

  AST_HDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.hdrShow && !ctl.hdrTake) |=> ctl.hdrShow && $stable(reqAddr) && $stable(reqDwLen)); // R12

endmodule

// File: rtl/dma_wr_segmenter.sv
module dma_wr_segmenter
  import wrseg_pkg::*;
#(
  parameter int ADDR_W        = 64,
  parameter int LEN_W         = 16,
  parameter int BOUND_LOG2    = 12,
  parameter int MPS_BASE_LOG2 = 7,
  parameter int MPS_CODE_MAX  = 5,
  localparam int DWLEN_W      = BOUND_LOG2 - 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [ADDR_W-1:0]  cmdAddr,
  input  logic [LEN_W-1:0]   cmdLen,
  input  logic [2:0]         cmdMps,
  output logic               busy,
  output logic               reqValid,
  input  logic               reqReady,
  output logic [ADDR_W-1:0]  reqAddr,
  output logic [DWLEN_W-1:0] reqDwLen,
  output logic [3:0]         reqFirstBe,
  output logic [3:0]         reqLastBe,
  input  logic               inValid,
  input  logic [7:0]         inByte,
  output logic               inReady,
  output logic               dataValid,
  input  logic               dataReady,
  output logic [31:0]        dataWord,
  output logic               dataLast,
  output logic               irqPulse,
  output logic               irqErr
);

  segCtl_t  ctl;
  segStat_t stat;

  wrseg_ctrl #(
    .LEN_W        (LEN_W),
    .MPS_CODE_MAX (MPS_CODE_MAX)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdLen   (cmdLen),
    .cmdMps   (cmdMps),
    .reqReady (reqReady),
    .stat     (stat),
    .ctl      (ctl),
    .reqValid (reqValid),
    .busy     (busy),
    .irqPulse (irqPulse),
    .irqErr   (irqErr)
  );

  wrseg_dpath #(
    .ADDR_W        (ADDR_W),
    .LEN_W         (LEN_W),
    .BOUND_LOG2    (BOUND_LOG2),
    .MPS_BASE_LOG2 (MPS_BASE_LOG2)
  ) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .cmdAddr    (cmdAddr),
    .cmdLen     (cmdLen),
    .cmdMps     (cmdMps),
    .reqAddr    (reqAddr),
    .reqDwLen   (reqDwLen),
    .reqFirstBe (reqFirstBe),
    .reqLastBe  (reqLastBe),
    .inValid    (inValid),
    .inByte     (inByte),
    .inReady    (inReady),
    .dataValid  (dataValid),
    .dataReady  (dataReady),
    .dataWord   (dataWord),
    .dataLast   (dataLast),
    .stat       (stat)
  );

endmodule

// File: tb/dma_wr_segmenter_tb_top.sv
module dma_wr_segmenter_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [63:0] cmdAddr = '0;
  logic [15:0] cmdLen = '0;
  logic [2:0]  cmdMps = '0;
  logic        busy, reqValid, inReady, dataValid, dataLast, irqPulse, irqErr;
  logic        reqReady = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inByte = '0;
  logic        dataReady = 1'b0;
  logic [63:0] reqAddr;
  logic [10:0] reqDwLen;
  logic [3:0]  reqFirstBe, reqLastBe;
  logic [31:0] dataWord;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk; // 200 MHz

  dma_wr_segmenter dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdAddr(cmdAddr), .cmdLen(cmdLen),
    .cmdMps(cmdMps), .busy(busy), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqDwLen(reqDwLen), .reqFirstBe(reqFirstBe), .reqLastBe(reqLastBe),
    .inValid(inValid), .inByte(inByte), .inReady(inReady), .dataValid(dataValid),
    .dataReady(dataReady), .dataWord(dataWord), .dataLast(dataLast),
    .irqPulse(irqPulse), .irqErr(irqErr)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int idx, input int salt);
    return 8'((idx * 13 + salt) & 255);
  endfunction

  function automatic int expChunk(input logic [63:0] a, input int rem, input int code);
    int mps, tb, mr, c;
    mps = 128 << code;
    tb  = 4096 - int'(a[11:0]);
    mr  = mps - (int'(a[11:0]) & (mps - 1));
    c = tb;
    if (mr < c) c = mr;
    if (rem < c) c = rem;
    return c;
  endfunction

  function automatic logic [3:0] expFirstBe(input logic [63:0] a, input int c);
    logic [3:0] be;
    for (int l = 0; l < 4; l++) be[l] = (l >= int'(a[1:0])) && (l < int'(a[1:0]) + c);
    return be;
  endfunction

  function automatic logic [3:0] expLastBe(input logic [63:0] a, input int c);
    int dw, e;
    dw = (int'(a[1:0]) + c + 3) / 4;
    e  = (int'(a[1:0]) + c) % 4;
    if (dw == 1) return 4'b0000;
    if (e == 0) return 4'b1111;
    return 4'((1 << e) - 1);
  endfunction

  function automatic logic [31:0] expWord(input logic [63:0] a, input int bytes,
                                          input int base, input int k, input int salt);
    logic [31:0] w;
    int pos;
    w = '0;
    for (int l = 0; l < 4; l++) begin
      pos = k * 4 + l - int'(a[1:0]);
      if (pos >= 0 && pos < bytes) w[l*8 +: 8] = pat(base + pos, salt);
    end
    return w;
  endfunction

  // full transfer with random stalls on all handshakes
  task automatic runXfer(input logic [63:0] a, input int len, input int code,
                         input bit inject, input int salt, input string tag);
    logic [63:0] expA, rA, holdAddr;
    int expRem, rBytes, rBase, rDw, dwIdx, inIdx, cyc, c;
    bit done, holdPend;
    @(negedge clk);
    cmdValid = 1'b1; cmdAddr = a; cmdLen = 16'(len); cmdMps = 3'(code);
    @(negedge clk);
    cmdValid = 1'b0;
    chk(busy == 1'b1, {tag, " R10 busy after start"}, 64'(busy), 1);
    expA = a; expRem = len; inIdx = 0; cyc = 0; done = 0; holdPend = 0;
    rA = '0; rBytes = 0; rBase = 0; rDw = 0; dwIdx = 0; holdAddr = '0;
    while (!done) begin
      if (irqPulse) chk(1'b0, {tag, " R7 early irq"}, 1, 0);
      if (holdPend)
        chk(reqValid && reqAddr == holdAddr, {tag, " R12 header hold"}, reqAddr, holdAddr);
      reqReady  = ($urandom % 4) != 0;
      dataReady = ($urandom % 4) != 0;
      inValid   = ($urandom % 4) != 0;
      inByte    = pat(inIdx, salt);
      if (inject && cyc == 6) begin
        cmdValid = 1'b1; cmdAddr = a + 64'h40; cmdLen = 16'd9; cmdMps = 3'd0;
      end else begin
        cmdValid = 1'b0;
      end
      holdPend = reqValid && !reqReady;
      holdAddr = reqAddr;
      if (reqValid && reqReady) begin
        if (expRem == 0) begin
          chk(1'b0, {tag, " R3 extra request"}, reqAddr, 0);
        end else begin
          c = expChunk(expA, expRem, code);
          chk(reqAddr == expA, {tag, " R3 address"}, reqAddr, expA);
          chk(int'(reqDwLen) == (int'(expA[1:0]) + c + 3) / 4, {tag, " R1 dword length"},
              64'(reqDwLen), 64'((int'(expA[1:0]) + c + 3) / 4));
          chk(reqFirstBe == expFirstBe(expA, c), {tag, " R4 first byte enable"},
              64'(reqFirstBe), 64'(expFirstBe(expA, c)));
          chk(reqLastBe == expLastBe(expA, c), {tag, " R5 last byte enable"},
              64'(reqLastBe), 64'(expLastBe(expA, c)));
          rA = expA; rBytes = c; rBase = len - expRem;
          rDw = (int'(expA[1:0]) + c + 3) / 4; dwIdx = 0;
          expA = expA + 64'(c); expRem = expRem - c;
        end
      end
      if (inValid && inReady) inIdx++;
      if (dataValid && dataReady) begin
        chk(dataWord == expWord(rA, rBytes, rBase, dwIdx, salt), {tag, " R6 payload lanes"},
            64'(dataWord), 64'(expWord(rA, rBytes, rBase, dwIdx, salt)));
        chk(dataLast == (dwIdx == rDw - 1), {tag, " R6 last flag"},
            64'(dataLast), 64'(dwIdx == rDw - 1));
        if (dataLast && expRem == 0) done = 1;
        dwIdx++;
      end
      @(negedge clk);
      cyc++;
      if (cyc > 30000) begin
        chk(1'b0, {tag, " R7 transfer timeout"}, 64'(cyc), 0);
        done = 1;
      end
    end
    cmdValid = 1'b0; reqReady = 1'b0; dataReady = 1'b0; inValid = 1'b0;
    chk(irqPulse == 1'b1 && irqErr == 1'b0, {tag, " R7 done pulse"}, {irqPulse, irqErr}, 2'b10);
    chk(busy == 1'b0, {tag, " R7 busy cleared"}, 64'(busy), 0);
    chk(inIdx == len, {tag, " R6 bytes consumed"}, 64'(inIdx), 64'(len));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!reqValid && !irqPulse && !busy, {tag, " R10 quiet after done"},
          {reqValid, irqPulse, busy}, 0);
    end
  endtask

  task automatic runShort(input logic [63:0] a, input int len, input int code,
                          input bit expErr, input string tag);
    @(negedge clk);
    cmdValid = 1'b1; cmdAddr = a; cmdLen = 16'(len); cmdMps = 3'(code);
    @(negedge clk);
    cmdValid = 1'b0;
    chk(irqPulse == 1'b1 && irqErr == expErr && !busy, tag,
        {irqPulse, irqErr, busy}, {1'b1, expErr, 1'b0});
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!reqValid && !irqPulse && !busy, {tag, " no request"}, {reqValid, irqPulse, busy}, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EC0_0D1E));
    repeat (3) @(negedge clk);
    chk(!busy && !reqValid && !dataValid && !inReady && !irqPulse, "R11 reset state",
        {busy, reqValid, dataValid, inReady, irqPulse}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !reqValid && !irqPulse, "R11 after release", {busy, reqValid, irqPulse}, 0);

    runXfer(64'h0000_0000_0000_1000, 256, 0, 0, 3, "R1 aligned split");
    runXfer(64'h0000_0010_0000_0FFA, 20, 5, 0, 5, "R2 4K cut");
    runXfer(64'h0000_0000_0000_0003, 1, 2, 0, 7, "R4 single byte");
    runXfer(64'h0000_0000_0000_0001, 2, 2, 0, 9, "R5 two bytes");
    runXfer(64'h0000_0000_0000_0002, 7, 1, 0, 11, "R5 three dwords");
    runXfer(64'h0000_0000_0000_0040, 300, 0, 0, 13, "R3 mid block");
    runXfer(64'h7ABC_0000_0000_1F7E, 900, 3, 0, 15, "R2 wide");
    runShort(64'h1000, 64, 6, 1'b1, "R8 code 6");
    runShort(64'h1000, 64, 7, 1'b1, "R8 code 7");
    runShort(64'h2000, 0, 2, 1'b0, "R9 zero length");
    runXfer(64'h0000_0000_0000_0805, 150, 0, 1, 17, "R10 ignored start");

    for (int t = 0; t < 25; t++) begin
      logic [63:0] ra;
      int rl, rc;
      ra = {1'b0, 31'($urandom), 32'($urandom)};
      if (($urandom % 3) == 0) ra[11:0] = 12'hFFF - 12'($urandom % 64);
      rl = 1 + int'($urandom % 700);
      rc = int'($urandom % 6);
      runXfer(ra, rl, rc, 0, t * 5 + 1, "R1 random");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule